// File: doc/BRIEF.md
# Target-Time Clock Output

This block turns a free-running raw time count into a clock output whose edges fall on absolute time targets. It holds a 64-bit target and a 64-bit period, both in the same scaled fixed-point units as the time count. When the time reaches or passes the target, the output level flips. In periodic mode the period is then added to the target, so each following edge lands exactly one period after the previous one. In one-shot mode the block stops after a single edge until a new target is written.

Software works out the first target so that the first edge lands on a whole second. It also loads the period as one second expressed in raw units. The block only compares, toggles and advances. An interrupt pulse can mark every level change. A small pin register decides whether the pad is driven at all and whether the pad carries this function or a constant low.

Top module: `tt_clkout`

## Requirements
- R1: After synchronous reset, pin_o, pin_oe and irq_o are 0, the block is disarmed, and the control, pin, period and target state are all zero.
- R2: In a cycle with ctl bit0 (enable) set, an armed target, no target or control write, and time_i >= target, the output level flips. The new level is visible on pin_o after that clock edge.
- R3: While time_i is below the target, the level does not change.
- R4: With ctl bit1 (sync) set, each edge adds the period to the target. If time has run several periods ahead, one edge follows per cycle until the target passes the time.
- R5: With ctl bit1 clear, exactly one edge occurs and the block disarms. Further edges need a new target write.
- R6: irq_o is a single-cycle pulse in the cycle after each edge, only when ctl bit2 (interrupt enable) was set. No pulse appears when the bit is clear.
- R7: A control write with bit0 clear forces the level to 0 at once. While bit0 is clear, no edge occurs. The control encoding is bit0 enable, bit1 sync, bit2 interrupt enable.
- R8: Pin register bit0 drives pin_oe. When bit1 (function select) is set, pin_o follows the level; when it is clear, pin_o is 0.
- R9: A target write loads the target and arms the block. A cycle that carries a target or control write produces no edge.
- R10: A period write takes effect for the next target advance after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_i | input | 64 | Raw scaled time count |
| per_wr | input | 1 | Period write strobe |
| per_i | input | 64 | Period value in raw units |
| tgt_wr | input | 1 | Target write strobe, arms the block |
| tgt_i | input | 64 | Target value in raw units |
| ctl_wr | input | 1 | Control write strobe |
| ctl_i | input | 3 | Control: bit0 enable, bit1 sync, bit2 interrupt enable |
| pin_wr | input | 1 | Pin register write strobe |
| pin_i | input | 2 | Pin: bit0 output enable, bit1 function select |
| pin_o | output | 1 | Pad data |
| pin_oe | output | 1 | Pad output enable |
| irq_o | output | 1 | One-cycle interrupt pulse per edge |

## Verification
The hardest situation to reach is catch-up: time has overtaken several pending targets at once, so back-to-back edges must appear while the target climbs one period per cycle. A second hard case is a target or control write that lands in the very cycle a match would fire. The bench drives the time count directly as an input. It jumps the count several periods ahead, and it places writes on cycles where the time already exceeds the target. Random steps, with occasional writes on top, then mix all of these together.

// File: rtl/tt_clkout_pkg.sv
package tt_clkout_pkg;
  localparam int CTL_W    = 3;
  localparam int CTL_EN   = 0;
  localparam int CTL_SYNC = 1;
  localparam int CTL_IRQ  = 2;
  localparam int PIN_W    = 2;
  localparam int PIN_DIR  = 0;
  localparam int PIN_FUNC = 1;

  typedef struct packed {
    logic irq_en;
    logic sync;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tt_clkout_cmp.sv
// Unsigned a >= b, split into lanes; the highest differing lane decides.
module tt_clkout_cmp #(
  parameter int W    = 64,
  parameter int LANE = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ge
);
  localparam int NL = W / LANE;

  logic [NL-1:0] gt_l;
  logic [NL-1:0] eq_l;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign gt_l[i] = a[i*LANE +: LANE] >  b[i*LANE +: LANE];
    assign eq_l[i] = a[i*LANE +: LANE] == b[i*LANE +: LANE];
  end

  always_comb begin
    ge = 1'b1;
    for (int i = 0; i < NL; i++) begin
      if (!eq_l[i]) ge = gt_l[i];
    end
  end
endmodule

// File: rtl/tt_clkout_sched.sv
// Target and period state; advances or disarms on each fired edge.
module tt_clkout_sched #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         per_wr,
  input  logic [W-1:0] per_i,
  input  logic         tgt_wr,
  input  logic [W-1:0] tgt_i,
  input  logic         fire,
  input  logic         sync,
  output logic [W-1:0] target_o,
  output logic [W-1:0] period_o,
  output logic         armed_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      target_o <= '0;
      period_o <= '0;
      armed_o  <= 1'b0;
    end else begin
      if (per_wr) period_o <= per_i;
      if (tgt_wr) begin
        target_o <= tgt_i;
        armed_o  <= 1'b1;
      end else if (fire) begin
        if (sync) target_o <= target_o + period_o;
        else      armed_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tt_clkout_drive.sv
// Output level, pad configuration and interrupt pulse, all registered.
module tt_clkout_drive
  import tt_clkout_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en_new,
  input  logic             fire,
  input  logic             irq_en,
  input  logic             pin_wr,
  input  logic [PIN_W-1:0] pin_i,
  output logic             level_o,
  output logic             pin_func_o,
  output logic             pin_o,
  output logic             pin_oe,
  output logic             irq_o
);
  logic             level_d;
  logic [PIN_W-1:0] pcfg_q;
  logic [PIN_W-1:0] pcfg_d;

  always_comb begin
    level_d = level_o;
    if (ctl_wr && !ctl_en_new) level_d = 1'b0;
    else if (fire)             level_d = ~level_o;
    pcfg_d = pin_wr ? pin_i : pcfg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o <= 1'b0;
      pcfg_q  <= '0;
      pin_o   <= 1'b0;
      pin_oe  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      level_o <= level_d;
      pcfg_q  <= pcfg_d;
      pin_o   <= pcfg_d[PIN_FUNC] & level_d;
      pin_oe  <= pcfg_d[PIN_DIR];
      irq_o   <= fire & irq_en;
    end
  end

  assign pin_func_o = pcfg_q[PIN_FUNC];
endmodule

// File: rtl/tt_clkout.sv
module tt_clkout
  import tt_clkout_pkg::*;
#(
  parameter int TW   = 64,
  parameter int LANE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TW-1:0]    time_i,
  input  logic             per_wr,
  input  logic [TW-1:0]    per_i,
  input  logic             tgt_wr,
  input  logic [TW-1:0]    tgt_i,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             pin_wr,
  input  logic [PIN_W-1:0] pin_i,
  output logic             pin_o,
  output logic             pin_oe,
  output logic             irq_o
);
  ctl_t          ctl_q;
  logic [TW-1:0] target;
  logic [TW-1:0] period;
  logic          armed;
  logic          reached;
  logic          fire;
  logic          level;
  logic          pin_func;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_t'(ctl_i);
  end

  tt_clkout_cmp #(.W(TW), .LANE(LANE)) u_cmp (
    .a(time_i), .b(target), .ge(reached)
  );

  assign fire = ctl_q.en && armed && reached && !tgt_wr && !ctl_wr;

  tt_clkout_sched #(.W(TW)) u_sched (
    .clk(clk), .rst(rst),
    .per_wr(per_wr), .per_i(per_i),
    .tgt_wr(tgt_wr), .tgt_i(tgt_i),
    .fire(fire), .sync(ctl_q.sync),
    .target_o(target), .period_o(period), .armed_o(armed)
  );

  tt_clkout_drive u_drive (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr), .ctl_en_new(ctl_i[CTL_EN]),
    .fire(fire), .irq_en(ctl_q.irq_en),
    .pin_wr(pin_wr), .pin_i(pin_i),
    .level_o(level), .pin_func_o(pin_func),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );
endmodule

// File: rtl/tt_clkout_chk.sv
module tt_clkout_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic          sync_q,
  input logic          irq_en_q,
  input logic          fire,
  input logic          level,
  input logic          armed,
  input logic [TW-1:0] target,
  input logic [TW-1:0] period,
  input logic          pin_func,
  input logic          pin_o,
  input logic          irq_o
);
  // R7
  level_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !level);
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(irq_en_q) && $past(fire)));
  // R6
  irq_edge_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (level != $past(level)));
  // R4
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && sync_q) |=> (target == $past(target) + $past(period)));
  // R5
  oneshot_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && !sync_q) |=> !armed);
  // R8
  pin_func_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_func |-> !pin_o);
endmodule

bind tt_clkout tt_clkout_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst(rst),
  .en_q(ctl_q.en), .sync_q(ctl_q.sync), .irq_en_q(ctl_q.irq_en),
  .fire(fire), .level(level), .armed(armed),
  .target(target), .period(period),
  .pin_func(pin_func), .pin_o(pin_o), .irq_o(irq_o)
);

// File: tb/tt_clkout_bench.sv
module tt_clkout_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  SHIFT      = 3;
  localparam logic [63:0] ONE_SEC = 64'd1_000_000_000 << SHIFT;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_i = '0;
  logic        per_wr = 0, tgt_wr = 0, ctl_wr = 0, pin_wr = 0;
  logic [63:0] per_i = '0, tgt_i = '0;
  logic [2:0]  ctl_i = '0;
  logic [1:0]  pin_i = '0;
  logic        pin_o, pin_oe, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R1";

  // reference state
  logic [63:0] m_tgt = '0, m_per = '0;
  logic        m_arm = 0, m_lvl = 0, m_irq = 0;
  logic [2:0]  m_ctl = '0;
  logic [1:0]  m_pin = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tt_clkout u_tt_clkout (
    .clk(clk), .rst(rst), .time_i(time_i),
    .per_wr(per_wr), .per_i(per_i), .tgt_wr(tgt_wr), .tgt_i(tgt_i),
    .ctl_wr(ctl_wr), .ctl_i(ctl_i), .pin_wr(pin_wr), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  function automatic logic [63:0] first_edge(input logic [63:0] raw);
    logic [63:0] ns, rem;
    ns  = raw >> SHIFT;
    rem = ns % 64'd1_000_000_000;
    return raw + ((64'd1_000_000_000 - rem) << SHIFT);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic fire, nl;
    fire = m_ctl[0] && m_arm && !tgt_wr && !ctl_wr && (time_i >= m_tgt);
    nl = m_lvl;
    if (ctl_wr && !ctl_i[0]) nl = 1'b0;
    else if (fire)           nl = ~m_lvl;
    m_irq = fire && m_ctl[2];
    if (tgt_wr) begin
      m_tgt = tgt_i; m_arm = 1'b1;
    end else if (fire) begin
      if (m_ctl[1]) m_tgt = m_tgt + m_per;
      else          m_arm = 1'b0;
    end
    if (per_wr) m_per = per_i;
    if (ctl_wr) m_ctl = ctl_i;
    if (pin_wr) m_pin = pin_i;
    m_lvl = nl;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    per_wr = 0; tgt_wr = 0; ctl_wr = 0; pin_wr = 0;
    check(cur_req, "pin_o",  pin_o,  m_pin[1] & m_lvl);
    check(cur_req, "pin_oe", pin_oe, m_pin[0]);
    check(cur_req, "irq_o",  irq_o,  m_irq);
  endtask

  task automatic wr_ctl(input logic [2:0] v); ctl_wr = 1; ctl_i = v; cyc(); endtask
  task automatic wr_pin(input logic [1:0] v); pin_wr = 1; pin_i = v; cyc(); endtask
  task automatic wr_tgt(input logic [63:0] v); tgt_wr = 1; tgt_i = v; cyc(); endtask
  task automatic wr_per(input logic [63:0] v); per_wr = 1; per_i = v; cyc(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] raw0, t0;
    void'($urandom(32'd7));
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1: reset state
    cur_req = "R1";
    check("R1", "reset pin_o", pin_o, 0);
    check("R1", "reset pin_oe", pin_oe, 0);
    check("R1", "reset irq_o", irq_o, 0);
    time_i = 64'd500; cyc();          // nothing armed, nothing enabled

    // R8: pad configuration
    cur_req = "R8";
    wr_pin(2'b01); wr_pin(2'b11);

    // second-aligned start, periodic
    cur_req = "R9";
    raw0 = 64'd123_456_789_012 << SHIFT;
    time_i = raw0;
    t0 = first_edge(raw0);
    wr_per(ONE_SEC);
    wr_tgt(t0);
    wr_ctl(3'b111);                   // enable, sync, irq
    cur_req = "R3";
    time_i = t0 - 1; cyc(); cyc();
    check("R3", "edge aligned to whole second", (t0 >> SHIFT) % 64'd1_000_000_000, 0);
    cur_req = "R2";
    time_i = t0; cyc();               // first edge, irq pulse
    cyc();                            // irq drops
    cur_req = "R4";
    time_i = t0 + ONE_SEC - 1; cyc();
    time_i = t0 + ONE_SEC; cyc();
    time_i = t0 + 4*ONE_SEC + 5;      // jumped past three targets
    repeat (5) cyc();                 // catch-up edges then quiet

    // R9: write collides with a match
    cur_req = "R9";
    wr_tgt(64'd10);                   // time far above: no edge this cycle
    cyc();                            // edge next
    wr_ctl(3'b111);                   // ctl write: no edge
    cyc();

    // R10: new period applies on next advance
    cur_req = "R10";
    time_i = 64'd1000;
    wr_tgt(64'd2000);
    wr_per(64'd300);
    time_i = 64'd2000; cyc();
    time_i = 64'd2299; cyc();
    time_i = 64'd2300; cyc();

    // R6: irq disabled
    cur_req = "R6";
    wr_ctl(3'b011);
    time_i = 64'd2600; cyc(); cyc();

    // R5: one-shot
    cur_req = "R5";
    wr_ctl(3'b101);
    wr_tgt(64'd3000);
    time_i = 64'd3000; cyc();
    time_i = 64'd9000; repeat (3) cyc();
    wr_tgt(64'd9500);
    time_i = 64'd9500; cyc(); cyc();

    // R7: disable clears and blocks
    cur_req = "R7";
    wr_ctl(3'b011);
    wr_tgt(64'd9600);
    time_i = 64'd9600; cyc();
    wr_ctl(3'b000);
    time_i = 64'd20000; repeat (3) cyc();
    wr_ctl(3'b111);
    cur_req = "R8";
    wr_pin(2'b01); cyc();
    wr_pin(2'b10); cyc();

    // random mix
    cur_req = "R4";
    time_i = 64'd20000;
    wr_per(64'd50);
    wr_pin(2'b11);
    wr_tgt(64'd20100);
    for (int i = 0; i < 2000; i++) begin
      int r;
      time_i = time_i + 64'($urandom_range(0, 60));
      r = $urandom_range(0, 99);
      if      (r < 3) begin ctl_wr = 1; ctl_i = 3'($urandom_range(0, 7)); end
      else if (r < 6) begin tgt_wr = 1; tgt_i = time_i + 64'($urandom_range(0, 300)); end
      else if (r < 8) begin per_wr = 1; per_i = 64'($urandom_range(1, 120)); end
      else if (r < 10) begin pin_wr = 1; pin_i = 2'($urandom_range(0, 3)); end
      else if (r < 11) time_i = time_i + 64'($urandom_range(200, 800));
      cyc();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule